// File: doc/BRIEF.md
# Boundary Self-Test Pattern Engine

This block runs built-in test operations directly on the shift stages of a boundary-scan register. It has 36 stages. The low 18 face input-mode pins and the high 18 face output-mode pins. A 3-bit control opcode, which an external scan chain loads, selects the operation:

- pseudo-random pattern generation over all stages;
- signature compression of the pin data over all stages;
- a binary up-count over all stages;
- one of two split modes. In both, the input half compresses a signature. At the same time the output half either generates patterns or counts.

The operation advances only on rising test-clock edges. On those edges the run-test instruction flag and the Run-Test/Idle state flag must both be high. On the falling edge after such an advance, the shadow latches copy the stages, and the shadow latches drive the output-mode pins.

TAP sequencing, instruction decode and the scan load of the opcode belong to the surrounding logic. Every interface is a plain per-clock level. No pin data is ever held back, so the block has no valid/ready handshake and no back-pressure rule.

Top module: `bst_engine`

## Requirements
- R1: The opcode `ctrl_op[2:0]` decodes as follows: 3'b001 generate (36-bit), 3'b010 signature (36-bit), 3'b011 split signature+generate, 3'b100 count (36-bit), 3'b101 split signature+count. The codes 3'b000, 3'b110 and 3'b111 are unassigned.
- R2: A rising `tck` edge advances the stages only when `run_instr` and `in_idle` are both high. Otherwise the stages hold and `shadow_out` does not change.
- R3: `shadow_out` takes the stage values on the falling `tck` edge that follows an active rising edge.
- R4: Generate mode sets the next state to {s[34:0], s[35]^s[24]}. An all-zero state is replaced by 36'h1, so the generator never locks up.
- R5: 36-bit signature mode sets the next state to {s[34:0], s[35]^s[24]} XOR `pin_in[35:0]`. This mode does not replace a zero state.
- R6: 36-bit count mode sets the next state to s+1, with stage 0 as the least significant bit.
- R7: In the split modes, the low half (stages 17..0) becomes {l[16:0], l[17]^l[10]} XOR `pin_in[17:0]`. The high half (stages 35..18) either steps as generator {h[16:0], h[17]^h[10]}, with 0 replaced by 1, or counts h+1.
- R8: While active, the unassigned opcodes leave the stages unchanged.
- R9: Reset (`rst_n` low) clears the stages and `shadow_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock. Stages update on the rising edge, shadow latches on the falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_instr | input | 1 | High while the run-test instruction is current |
| in_idle | input | 1 | High while the TAP is in Run-Test/Idle |
| ctrl_op | input | 3 | Control opcode from the boundary-control register |
| pin_in | input | 36 | Sampled pin data, with input-mode pins in bits 17..0 |
| shadow_out | output | 36 | Shadow latch values driving the output-mode pins |

## Verification
On every edge, the assertions check four things:
- an inactive edge leaves the stages untouched;
- an unassigned opcode freezes them;
- a count step adds exactly one;
- the generator state is never zero after a generate step.

They also check that after any active edge, the shadow latches equal the stages at the next rising edge. Only the bench's scenarios can show the exact sequences: the polynomial feedback taps, how pin data folds into both signature widths, and the split-half boundary. The bench compares these against a reference model across mode changes and with the qualifying flags dropped.

// File: rtl/bst_pkg.sv
package bst_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'b000,
    OP_GEN    = 3'b001,
    OP_SIG    = 3'b010,
    OP_SIGGEN = 3'b011,
    OP_CNT    = 3'b100,
    OP_SIGCNT = 3'b101,
    OP_RSV6   = 3'b110,
    OP_RSV7   = 3'b111
  } bst_op_e;

  typedef enum logic [1:0] {
    SEG_HOLD = 2'd0,
    SEG_GEN  = 2'd1,
    SEG_SIG  = 2'd2,
    SEG_CNT  = 2'd3
  } seg_mode_e;
endpackage

// File: rtl/bst_decode.sv
module bst_decode
  import bst_pkg::*;
(
  input  logic      tck,
  input  logic      rst_n,
  input  logic      run_instr,
  input  logic      in_idle,
  input  logic [2:0] ctrl_op,
  output logic      active,
  output logic      split,
  output seg_mode_e full_mode,
  output seg_mode_e lo_mode,
  output seg_mode_e hi_mode
);
  assign active = run_instr & in_idle;

  always_comb begin
    split     = 1'b0;
    full_mode = SEG_HOLD;
    lo_mode   = SEG_HOLD;
    hi_mode   = SEG_HOLD;
    if (active) begin
      case (bst_op_e'(ctrl_op))
        OP_GEN:    full_mode = SEG_GEN;
        OP_SIG:    full_mode = SEG_SIG;
        OP_CNT:    full_mode = SEG_CNT;
        OP_SIGGEN: begin split = 1'b1; lo_mode = SEG_SIG; hi_mode = SEG_GEN; end
        OP_SIGCNT: begin split = 1'b1; lo_mode = SEG_SIG; hi_mode = SEG_CNT; end
        default:   ;
      endcase
    end
  end

  // R7: in split operation the input half compresses and the output half never does
  assert_split_roles_R7: assert property (@(posedge tck) disable iff (!rst_n)
    split |-> (lo_mode == SEG_SIG && hi_mode != SEG_SIG && hi_mode != SEG_HOLD));
endmodule

// File: rtl/bst_seg.sv
module bst_seg
  import bst_pkg::*;
#(
  parameter int W   = 36,
  parameter int TAP = 25
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] pins,
  input  seg_mode_e    mode,
  output logic [W-1:0] nxt
);
  logic         fb;
  logic [W-1:0] shifted;

  assign fb      = cur[W-1] ^ cur[TAP-1];
  assign shifted = {cur[W-2:0], fb};

  always_comb begin
    case (mode)
      SEG_GEN:  nxt = (cur == '0) ? W'(1) : shifted;
      SEG_SIG:  nxt = shifted ^ pins;
      SEG_CNT:  nxt = cur + W'(1);
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/bst_shadow.sv
module bst_shadow #(
  parameter int W = 36
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] stg,
  output logic [W-1:0] sh
);
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)   sh <= '0;
    else if (upd) sh <= stg;
  end
endmodule

// File: rtl/bst_engine.sv
module bst_engine
  import bst_pkg::*;
#(
  parameter int STAGES   = 36,
  parameter int TAP_FULL = 25,
  parameter int TAP_HALF = 11
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              run_instr,
  input  logic              in_idle,
  input  logic [2:0]        ctrl_op,
  input  logic [STAGES-1:0] pin_in,
  output logic [STAGES-1:0] shadow_out
);
  localparam int HALF = STAGES / 2;

  logic              active, split, upd_q;
  seg_mode_e         full_mode, lo_mode, hi_mode;
  logic [STAGES-1:0] stg_q, full_nxt, stg_nxt;
  logic [HALF-1:0]   lo_nxt, hi_nxt;

  bst_decode u_decode (
    .tck, .rst_n, .run_instr, .in_idle, .ctrl_op,
    .active, .split, .full_mode, .lo_mode, .hi_mode
  );

  bst_seg #(.W(STAGES), .TAP(TAP_FULL)) u_full (
    .cur(stg_q), .pins(pin_in), .mode(full_mode), .nxt(full_nxt)
  );

  generate
    if (HALF > TAP_HALF) begin : g_split
      bst_seg #(.W(HALF), .TAP(TAP_HALF)) u_lo (
        .cur(stg_q[HALF-1:0]), .pins(pin_in[HALF-1:0]), .mode(lo_mode), .nxt(lo_nxt)
      );
      bst_seg #(.W(HALF), .TAP(TAP_HALF)) u_hi (
        .cur(stg_q[STAGES-1:HALF]), .pins(pin_in[STAGES-1:HALF]), .mode(hi_mode), .nxt(hi_nxt)
      );
    end else begin : g_nosplit
      assign lo_nxt = stg_q[HALF-1:0];
      assign hi_nxt = stg_q[STAGES-1:HALF];
    end
  endgenerate

  assign stg_nxt = split ? {hi_nxt, lo_nxt} : full_nxt;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      upd_q <= 1'b0;
    end else begin
      stg_q <= stg_nxt;
      upd_q <= active;
    end
  end

  bst_shadow #(.W(STAGES)) u_shadow (
    .tck, .rst_n, .upd(upd_q), .stg(stg_q), .sh(shadow_out)
  );

  assert_hold_inactive_R2: assert property (@(posedge tck) disable iff (!rst_n)
    !active |=> $stable(stg_q));

  assert_shadow_follow_R3: assert property (@(posedge tck) disable iff (!rst_n)
    $past(active) |-> (shadow_out == stg_q));

  assert_gen_nonzero_R4: assert property (@(posedge tck) disable iff (!rst_n)
    (active && ctrl_op == OP_GEN) |=> (stg_q != '0));

  assert_count_step_R6: assert property (@(posedge tck) disable iff (!rst_n)
    (active && ctrl_op == OP_CNT) |=> (stg_q == $past(stg_q) + STAGES'(1)));

  assert_unassigned_hold_R8: assert property (@(posedge tck) disable iff (!rst_n)
    (active && (ctrl_op == OP_NONE || ctrl_op == OP_RSV6 || ctrl_op == OP_RSV7))
      |=> $stable(stg_q));
endmodule

// File: tb/bst_engine_tb.sv
`timescale 1ns/1ps
module bst_engine_tb;
  logic        tck = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_instr = 1'b0;
  logic        in_idle = 1'b0;
  logic [2:0]  ctrl_op = 3'b000;
  logic [35:0] pin_in = '0;
  logic [35:0] shadow_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    longint      due;
    logic [35:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  logic [35:0] m_stg = '0;
  logic [35:0] m_sh  = '0;

  always #4 tck = ~tck;

  bst_engine u_dut (
    .tck, .rst_n, .run_instr, .in_idle, .ctrl_op, .pin_in, .shadow_out
  );

  function automatic logic [35:0] ref_step(logic [2:0] op, logic [35:0] s, logic [35:0] p);
    logic [17:0] lo, hi;
    lo = s[17:0];
    hi = s[35:18];
    case (op)
      3'b001: return (s == 0) ? 36'h1 : {s[34:0], s[35] ^ s[24]};
      3'b010: return {s[34:0], s[35] ^ s[24]} ^ p;
      3'b100: return s + 36'd1;
      3'b011: begin
        lo = {lo[16:0], lo[17] ^ lo[10]} ^ p[17:0];
        hi = (hi == 0) ? 18'h1 : {hi[16:0], hi[17] ^ hi[10]};
        return {hi, lo};
      end
      3'b101: begin
        lo = {lo[16:0], lo[17] ^ lo[10]} ^ p[17:0];
        hi = hi + 18'd1;
        return {hi, lo};
      end
      default: return s;
    endcase
  endfunction

  task automatic drive(input logic [2:0] op, input logic run, input logic idle,
                       input logic [35:0] p, input string req);
    item_t it;
    @(negedge tck);
    #1;
    ctrl_op = op; run_instr = run; in_idle = idle; pin_in = p;
    if (run && idle) begin
      m_stg = ref_step(op, m_stg, p);
      m_sh  = m_stg;
    end
    it.due = $time + 10;
    it.exp = m_sh;
    it.req = req;
    sb.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge tck);
      #3;
      while (sb.size() > 0 && sb[0].due <= $time) begin
        it = sb.pop_front();
        checks++;
        if (shadow_out !== it.exp) begin
          errors++;
          $display("FAIL %s: shadow_out=%h expected=%h", it.req, shadow_out, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge tck);
    // R9: reset state
    checks++;
    if (shadow_out !== 36'h0) begin
      errors++;
      $display("FAIL R9: shadow_out=%h expected=%h", shadow_out, 36'h0);
    end
    #1 rst_n = 1'b1;

    // R4: generator seeds from zero, then shifts with feedback from bits 35 and 24
    for (int i = 0; i < 40; i++) drive(3'b001, 1, 1, '0, "R4");
    // R2: dropping either qualifier freezes everything
    drive(3'b001, 0, 1, '0, "R2");
    drive(3'b001, 1, 0, '0, "R2");
    drive(3'b100, 0, 0, 36'hFFFFFFFFF, "R2");
    // R3: shadow copies stages after active edge
    drive(3'b001, 1, 1, '0, "R3");
    // R8: unassigned codes hold while active
    drive(3'b000, 1, 1, 36'h123456789, "R8");
    drive(3'b110, 1, 1, 36'hABCDEF012, "R8");
    drive(3'b111, 1, 1, 36'hFFFFFFFFF, "R8");
    // R5: 36-bit signature with several pin patterns
    for (int i = 0; i < 12; i++)
      drive(3'b010, 1, 1, {4'(i), 32'hA5A5_0F0F ^ (32'h1 << i)}, "R5");
    drive(3'b010, 1, 1, 36'hFFFFFFFFF, "R5");
    drive(3'b010, 1, 1, 36'h000000000, "R5");
    // R6: count up across a carry chain
    for (int i = 0; i < 10; i++) drive(3'b100, 1, 1, 36'h5A5A5A5A5, "R6");
    // R7: split signature + generate
    for (int i = 0; i < 20; i++) drive(3'b011, 1, 1, {18'h3FFFF, 18'(i * 37)}, "R7");
    // R7: split signature + count
    for (int i = 0; i < 20; i++) drive(3'b101, 1, 1, {18'h0, 18'h2AAAA ^ 18'(i)}, "R7");
    // R1: switch among all assigned codes in turn
    drive(3'b001, 1, 1, 36'h0, "R1");
    drive(3'b010, 1, 1, 36'h00F00F00F, "R1");
    drive(3'b011, 1, 1, 36'h1, "R1");
    drive(3'b100, 1, 1, 36'h0, "R1");
    drive(3'b101, 1, 1, 36'h3, "R1");
    drive(3'b000, 0, 0, 36'h0, "R2");
    repeat (4) @(negedge tck);
    #5;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: pending=%0d expected=0", sb.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule